// File: doc/BRIEF.md
# Strap Mode Decoder with Master Clock Generator

This block turns a 4-bit configuration strap into the settings of a stereo audio converter port. Those settings are: bus role, DC-blocking filter enable, serial format, speed-selection policy, speed class and bit-clock divide. When the strap picks a master mode, the block divides the master clock into a bit clock at 64 times the sample rate and a frame clock at the sample rate. The frame clock is low for the left channel and high for the right, as in I2S. The block also raises a one-cycle strobe at the start of each left half.

The block runs on the master clock. The active-low power-down input also acts as its asynchronous reset. A small controller moves through four named states. DOWN is held while power-down is active. LATCH is the single cycle in which the strap is captured. SLAVE and MASTER are the two operating states. The transitions are: DOWN to LATCH on the first clock edge after release; LATCH to MASTER when the strap value is 12 or more, otherwise LATCH to SLAVE; SLAVE and MASTER hold until power-down. Asserting power-down returns the controller to DOWN from any state.

Top module: `mstrap_ctrl`

## Requirements
- R1: While `i_pdn_n` is low, every output is 0, and this takes effect at once without waiting for a clock edge.
- R2: The strap is sampled at the second rising `i_mclk` edge after `i_pdn_n` rises, and the control outputs take their decoded values at that edge. They are still 0 after the first edge. Later strap changes have no effect until the next power-down.
- R3: `o_master` is 1 for strap values 12 to 15 and 0 for values 0 to 11.
- R4: `o_fmt` is 2'b01 (I2S) in every master mode. In slave modes it equals strap bits 3:2: 2'b00 means MSB-justified output with LSB-justified input, 2'b01 means I2S, and 2'b10 means left-justified.
- R5: `o_hpf_en` is 1 in every master mode. In slave modes it is the inverse of strap bit 1.
- R6: `o_auto_speed` is 0 in master modes. In slave modes it is the inverse of strap bit 0.
- R7: `o_speed` uses the codes 00 normal, 01 double and 10 quad. `o_div` gives the master clocks per bit clock. Strap 12 gives 01 and 4, strap 13 gives 00 and 8, strap 14 gives 10 and 2, strap 15 gives 00 and 4. Slave modes give 00 and 0.
- R8: In a master mode, `o_bclk` is 0 at the sampling edge and then toggles every `o_div`/2 master clock edges, giving a 50% duty cycle.
- R9: In a master mode, `o_lrck` is 0 at the sampling edge and toggles only at the edge where `o_bclk` falls. It toggles once every 32 bit-clock periods.
- R10: `o_frame_start` is 1 for exactly one cycle at the sampling edge and at each 1-to-0 change of `o_lrck`, and is 0 at all other times.
- R11: In slave modes, `o_bclk`, `o_lrck` and `o_frame_start` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_mclk | input | 1 | Master clock |
| i_pdn_n | input | 1 | Power-down, active low, asynchronous |
| i_strap | input | 4 | Mode strap |
| o_master | output | 1 | 1 = block drives the bit and frame clocks |
| o_hpf_en | output | 1 | DC-blocking filter enable |
| o_fmt | output | 2 | Serial format code |
| o_auto_speed | output | 1 | Speed class chosen from the clock ratio (slave) |
| o_speed | output | 2 | Speed class code |
| o_div | output | 4 | Master clocks per bit clock (master) |
| o_bclk | output | 1 | Generated bit clock |
| o_lrck | output | 1 | Generated frame clock |
| o_frame_start | output | 1 | One-cycle strobe at each left-half start |

## Verification
Decoded controls are due at the second rising edge after power-down is released, and the bench checks that they are still zero after the first edge. From that sampling edge the bench counts edges k itself. From k it computes the level each clock should have: the bit clock after k/(div/2) toggles, the frame clock after k/(32·div) toggles, and the strobe when k is a multiple of 64·div. The bench compares every output at the falling edge of every cycle. Power-down is asserted in mid-run, and the outputs are checked 1 ns later without waiting for a clock edge.

// File: rtl/mstrap_pkg.sv
`timescale 1ns/1ps
package mstrap_pkg;
    localparam int STRAP_W    = 4;
    localparam int DIV_W      = 4;
    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    // master clocks per frame for the four master straps
    localparam int OSR_M12 = 256;
    localparam int OSR_M13 = 512;
    localparam int OSR_M14 = 128;
    localparam int OSR_M15 = 256;
    localparam int DIV_M12 = OSR_M12 / FRAME_BITS;
    localparam int DIV_M13 = OSR_M13 / FRAME_BITS;
    localparam int DIV_M14 = OSR_M14 / FRAME_BITS;
    localparam int DIV_M15 = OSR_M15 / FRAME_BITS;

    typedef enum logic [1:0] {
        FMT_MIXED = 2'b00,
        FMT_I2S   = 2'b01,
        FMT_LEFT  = 2'b10
    } fmt_e;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10
    } speed_e;

    typedef struct packed {
        logic             master;
        logic             hpf_en;
        fmt_e             fmt;
        logic             auto_spd;
        speed_e           speed;
        logic [DIV_W-1:0] div;
    } mode_cfg_t;

    typedef enum logic [1:0] {
        ST_DOWN   = 2'd0,
        ST_LATCH  = 2'd1,
        ST_SLAVE  = 2'd2,
        ST_MASTER = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/mstrap_decode.sv
`timescale 1ns/1ps
module mstrap_decode
    import mstrap_pkg::*;
(
    input  logic [STRAP_W-1:0] strap,
    output mode_cfg_t          cfg
);
    always_comb begin
        cfg = '0;
        if (strap[3:2] == 2'b11) begin
            cfg.master   = 1'b1;
            cfg.hpf_en   = 1'b1;
            cfg.fmt      = FMT_I2S;
            cfg.auto_spd = 1'b0;
            unique case (strap[1:0])
                2'b00: begin cfg.speed = SPD_DOUBLE; cfg.div = DIV_W'(DIV_M12); end
                2'b01: begin cfg.speed = SPD_NORMAL; cfg.div = DIV_W'(DIV_M13); end
                2'b10: begin cfg.speed = SPD_QUAD;   cfg.div = DIV_W'(DIV_M14); end
                2'b11: begin cfg.speed = SPD_NORMAL; cfg.div = DIV_W'(DIV_M15); end
            endcase
        end else begin
            cfg.master   = 1'b0;
            cfg.hpf_en   = ~strap[1];
            cfg.fmt      = fmt_e'(strap[3:2]);
            cfg.auto_spd = ~strap[0];
            cfg.speed    = SPD_NORMAL;
            cfg.div      = '0;
        end
    end
endmodule

// File: rtl/mstrap_clkgen.sv
`timescale 1ns/1ps
module mstrap_clkgen #(
    parameter int DIV_W     = 4,
    parameter int SLOT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             bclk,
    output logic             lrck,
    output logic             fstart
);
    localparam int CNT_W = $clog2(SLOT_BITS);

    logic             active_q;
    logic [DIV_W-1:0] hcnt_q;
    logic [CNT_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            hcnt_q   <= '0;
            slot_q   <= '0;
            bclk     <= 1'b0;
            lrck     <= 1'b0;
            fstart   <= 1'b0;
        end else if (!run) begin
            active_q <= 1'b0;
            hcnt_q   <= '0;
            slot_q   <= '0;
            bclk     <= 1'b0;
            lrck     <= 1'b0;
            fstart   <= 1'b0;
        end else if (!active_q) begin
            active_q <= 1'b1;
            hcnt_q   <= '0;
            slot_q   <= '0;
            bclk     <= 1'b0;
            lrck     <= 1'b0;
            fstart   <= 1'b1;
        end else begin
            fstart <= 1'b0;
            if (hcnt_q == half - DIV_W'(1)) begin
                hcnt_q <= '0;
                bclk   <= ~bclk;
                if (bclk) begin
                    if (slot_q == CNT_W'(SLOT_BITS - 1)) begin
                        slot_q <= '0;
                        lrck   <= ~lrck;
                        fstart <= lrck;
                    end else begin
                        slot_q <= slot_q + CNT_W'(1);
                    end
                end
            end else begin
                hcnt_q <= hcnt_q + DIV_W'(1);
            end
        end
    end

    // R9
    lrck_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lrck != $past(lrck)) |-> ($past(bclk) && !bclk));
    // R10
    fstart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fstart |=> !fstart);
    // R10
    fstart_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fstart |-> (!lrck && !bclk));
endmodule

// File: rtl/mstrap_ctrl.sv
`timescale 1ns/1ps
module mstrap_ctrl
    import mstrap_pkg::*;
(
    input  logic               i_mclk,
    input  logic               i_pdn_n,
    input  logic [STRAP_W-1:0] i_strap,
    output logic               o_master,
    output logic               o_hpf_en,
    output logic [1:0]         o_fmt,
    output logic               o_auto_speed,
    output logic [1:0]         o_speed,
    output logic [DIV_W-1:0]   o_div,
    output logic               o_bclk,
    output logic               o_lrck,
    output logic               o_frame_start
);
    ctl_state_e state_q, state_d;
    mode_cfg_t  dec_cfg, cfg_q;
    logic [DIV_W-1:0] half_div;

    mstrap_decode u_decode (
        .strap (i_strap),
        .cfg   (dec_cfg)
    );

    // state register
    always_ff @(posedge i_mclk or negedge i_pdn_n) begin
        if (!i_pdn_n) state_q <= ST_DOWN;
        else          state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DOWN:   state_d = ST_LATCH;
            ST_LATCH:  state_d = dec_cfg.master ? ST_MASTER : ST_SLAVE;
            ST_SLAVE:  state_d = ST_SLAVE;
            ST_MASTER: state_d = ST_MASTER;
        endcase
    end

    // output register: strap captured only in LATCH
    always_ff @(posedge i_mclk or negedge i_pdn_n) begin
        if (!i_pdn_n)                 cfg_q <= '0;
        else if (state_q == ST_LATCH) cfg_q <= dec_cfg;
    end

    assign half_div = {1'b0, cfg_q.div[DIV_W-1:1]};

    mstrap_clkgen #(
        .DIV_W     (DIV_W),
        .SLOT_BITS (SLOT_BITS)
    ) u_clkgen (
        .clk    (i_mclk),
        .rst_n  (i_pdn_n),
        .run    (state_d == ST_MASTER),
        .half   (half_div),
        .bclk   (o_bclk),
        .lrck   (o_lrck),
        .fstart (o_frame_start)
    );

    assign o_master     = cfg_q.master;
    assign o_hpf_en     = cfg_q.hpf_en;
    assign o_fmt        = cfg_q.fmt;
    assign o_auto_speed = cfg_q.auto_spd;
    assign o_speed      = cfg_q.speed;
    assign o_div        = cfg_q.div;

    // R11
    slave_quiet_chk: assert property (@(posedge i_mclk) disable iff (!i_pdn_n)
        (state_q != ST_MASTER) |-> (!o_bclk && !o_lrck && !o_frame_start));
    // R2
    cfg_frozen_chk: assert property (@(posedge i_mclk) disable iff (!i_pdn_n)
        (($past(state_q) == ST_SLAVE) || ($past(state_q) == ST_MASTER)) |-> $stable(cfg_q));
    // R5
    master_hpf_chk: assert property (@(posedge i_mclk) disable iff (!i_pdn_n)
        o_master |-> (o_hpf_en && !o_auto_speed));
endmodule

// File: tb/tb_mstrap_ctrl.sv
`timescale 1ns/1ps
module tb_mstrap_ctrl;
    logic       clk = 1'b0;
    logic       pdn_n = 1'b0;
    logic [3:0] strap = 4'd0;
    logic       o_master, o_hpf_en, o_auto_speed, o_bclk, o_lrck, o_frame_start;
    logic [1:0] o_fmt, o_speed;
    logic [3:0] o_div;
    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mstrap_ctrl dut (
        .i_mclk(clk), .i_pdn_n(pdn_n), .i_strap(strap),
        .o_master(o_master), .o_hpf_en(o_hpf_en), .o_fmt(o_fmt),
        .o_auto_speed(o_auto_speed), .o_speed(o_speed), .o_div(o_div),
        .o_bclk(o_bclk), .o_lrck(o_lrck), .o_frame_start(o_frame_start)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // {master, hpf, fmt[1:0], auto, speed[1:0], div[3:0]}
    function automatic logic [10:0] exp_cfg(input logic [3:0] s);
        if (s >= 4'd12) begin
            case (s)
                4'd12:   return {1'b1, 1'b1, 2'b01, 1'b0, 2'b01, 4'd4};
                4'd13:   return {1'b1, 1'b1, 2'b01, 1'b0, 2'b00, 4'd8};
                4'd14:   return {1'b1, 1'b1, 2'b01, 1'b0, 2'b10, 4'd2};
                default: return {1'b1, 1'b1, 2'b01, 1'b0, 2'b00, 4'd4};
            endcase
        end
        return {1'b0, ~s[1], s[3:2], ~s[0], 2'b00, 4'd0};
    endfunction

    function automatic logic exp_bclk(input int k, input int h);
        return ((k / h) % 2) == 1;
    endfunction
    function automatic logic exp_lrck(input int k, input int h);
        return ((k / (64 * h)) % 2) == 1;
    endfunction
    function automatic logic exp_fs(input int k, input int h);
        return (k % (128 * h)) == 0;
    endfunction

    task automatic zero_chk(input string tag);
        chk(tag, {o_master, o_hpf_en, o_fmt, o_auto_speed, o_speed, o_div,
                  o_bclk, o_lrck, o_frame_start}, 32'd0);
    endtask

    task automatic run_mode(input logic [3:0] s, input int ncyc, input bit flip);
        logic [10:0] e;
        int h;
        e = exp_cfg(s);
        h = (e[3:0] == 4'd0) ? 1 : int'(e[3:0]) / 2;
        @(negedge clk);
        strap = s;
        repeat (2) @(negedge clk);
        zero_chk("R1 outputs during power-down");
        pdn_n = 1'b1;
        @(posedge clk); @(negedge clk);
        zero_chk("R2 outputs after first edge");
        @(posedge clk); @(negedge clk);
        for (int k = 0; k < ncyc; k++) begin
            chk("R3 master", o_master, e[10]);
            chk("R5 hpf", o_hpf_en, e[9]);
            chk("R4 fmt", o_fmt, e[8:7]);
            chk("R6 auto speed", o_auto_speed, e[6]);
            chk("R7 speed", o_speed, e[5:4]);
            chk("R7 div", o_div, e[3:0]);
            if (e[10]) begin
                chk("R8 bclk", o_bclk, exp_bclk(k, h));
                chk("R9 lrck", o_lrck, exp_lrck(k, h));
                chk("R10 frame start", o_frame_start, exp_fs(k, h));
            end else begin
                chk("R11 slave clocks", {o_bclk, o_lrck, o_frame_start}, 3'b000);
            end
            if (flip && k == 5) strap = 4'($urandom); // R2: must be ignored
            @(posedge clk); @(negedge clk);
        end
        pdn_n = 1'b0;
        #1;
        zero_chk("R1 asynchronous power-down");
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // directed: every strap once, master ones over two full frames
        for (int s = 0; s < 16; s++)
            run_mode(4'(s), (s >= 12) ? 1100 : 40, (s % 3) == 0);
        // corner: fastest divide with strap flipping right after capture
        run_mode(4'd14, 300, 1'b1);
        // random straps and run lengths
        for (int i = 0; i < 14; i++) begin
            logic [3:0] rs;
            rs = 4'($urandom % 16);
            run_mode(rs, 50 + int'($urandom % 1100), 1'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule